// File: doc/BRIEF.md
# Single-Thread Decode Stage Controller

This block sits between fetch and the next stage of an in-order front end, handling one thread. Each cycle fetch presents a bundle of up to `FETCH_W` instruction tokens (in lanes 0 upward), and the stage forwards at most `DEC_W` of them downstream. Each token carries a sequence number, a "dead" flag meaning it was squashed earlier, and a source-register count. Dead tokens are dropped without using an output slot. A token with no source registers is marked ready to issue as it passes. No real decoding is done.

The rename, execute and commit stages can each hold the stage with a hold pulse and let it go with a release pulse. While held, arriving tokens are parked in a skid buffer of `F2D_DELAY*FETCH_W + DEC_W` entries. When the holds clear, the stage enters an unblocking phase. In that phase it empties the skid buffer oldest first and appends new arrivals to it. It signals fetch to resume only once the buffer is empty. A commit flush discards everything and reports how many incoming tokens it dropped. A reorder-buffer squash in progress keeps the stage in its squashing phase.

All outputs are combinational in the current cycle's inputs and registered state. Phase and buffer contents change at the clock edge.

Top module: `decode_stage`

## Requirements
- R1: After synchronous active-low reset: `phase` is 0 (Idle), the skid buffer is empty, and the stall flags, `hold_err` and `skid_ovf` are 0. The phase encoding is 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing.
- R2: In Idle or Running, the stage scans lanes from 0 upward and sends at most `DEC_W` live tokens. Slot 0 gets the oldest. Dead tokens are skipped without using a slot. `dn_ready[i]` is 1 when slot i's token has a source count of 0. Unused slots drive zero.
- R3: If fetch lanes remain unscanned after `DEC_W` tokens were sent, they go to the skid buffer and the phase becomes Blocked. In the same cycle `fe_stop` pulses, unless the phase was already Blocked.
- R4: Each source's stall flag is set by its hold pulse and cleared by its release pulse; a release in the same cycle as a hold wins. While any flag is set, all incoming tokens go to the skid buffer and the phase becomes Blocked. `fe_stop` pulses only when the phase was not Blocked.
- R5: With no flag set, a Blocked stage behaves by skid-buffer state. If the buffer is empty, it pulses `fe_go` and decodes as Running. Otherwise it decodes from the skid buffer, examining at most `FETCH_W` entries, appends arrivals, and stays in Unblocking. When nothing remains after that, it pulses `fe_go` and moves to Running.
- R6: A commit flush (`cmt_flush`) sends nothing, empties the skid buffer and reports `fe_cnt` on `flush_cnt`. It pulses `fe_go` if the phase was Blocked or Unblocking, and moves to Squashing. From Squashing, a quiet cycle moves to Running and decodes.
- R7: A reorder-buffer squash in progress (`rob_busy`) sends nothing, discards the incoming bundle and keeps or enters Squashing.
- R8: Priority is commit flush, then reorder-buffer squash, then stall.
- R9: A release pulse for a stall flag that is clear (and not set in the same cycle) sets `hold_err`, which stays set until reset.
- R10: Tokens pushed beyond the skid capacity are dropped, newest first. The overflow sets `skid_ovf`, which stays set until reset.
- R11: An empty bundle in Idle or Running leaves the phase unchanged. Idle decodes like Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_cnt | input | CNT_W | Number of valid lanes in the fetch bundle |
| fe_seq | input | FETCH_W*SEQ_W | Sequence number per lane |
| fe_dead | input | FETCH_W | Lane token already squashed |
| fe_nsrc | input | FETCH_W*SRC_W | Source-register count per lane |
| ren_hold | input | 1 | Rename stall set pulse |
| ren_release | input | 1 | Rename stall clear pulse |
| exe_hold | input | 1 | Execute stall set pulse |
| exe_release | input | 1 | Execute stall clear pulse |
| cmt_hold | input | 1 | Commit stall set pulse |
| cmt_release | input | 1 | Commit stall clear pulse |
| cmt_flush | input | 1 | Commit flush |
| rob_busy | input | 1 | Reorder-buffer squash in progress |
| dn_cnt | output | OCNT_W | Tokens sent downstream this cycle |
| dn_seq | output | DEC_W*SEQ_W | Sequence numbers sent, slot 0 oldest |
| dn_ready | output | DEC_W | Slot token ready to issue |
| fe_stop | output | 1 | Block pulse to fetch |
| fe_go | output | 1 | Unblock pulse to fetch |
| flush_cnt | output | CNT_W | Incoming tokens dropped by a flush |
| phase | output | 3 | Current phase |
| hold_err | output | 1 | Sticky stall-release error |
| skid_ovf | output | 1 | Sticky skid overflow |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Dead token mid-bundle:** a design that wastes an output slot on the dead token loses a live one to the skid buffer.
- **Leftover lanes while already Blocked:** a design that re-pulses `fe_stop` double-blocks fetch.
- **Flush while Blocked with parked tokens:** a design that keeps the skid buffer replays flushed tokens after the next block.
- **Unblocking across several cycles with new arrivals:** this exposes both out-of-order drain and an early `fe_go`.
- **Simultaneous flush, squash and stall:** this checks the priority order.
- **Three held bundles that exceed the buffer:** the drain shows which tokens were dropped.

// File: rtl/dec_pkg.sv
// Shared types for the decode stage: the token carried per lane and the
// per-thread phase encoding. Token field widths are fixed here.
package dec_pkg;
    localparam int SEQ_W   = 8;
    localparam int SRC_W   = 3;
    localparam int N_STALL = 3;

    typedef struct packed {
        logic             dead;
        logic [SRC_W-1:0] nsrc;
        logic [SEQ_W-1:0] seq;
    } tok_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RUN  = 3'd1,
        PH_BLK  = 3'd2,
        PH_UNB  = 3'd3,
        PH_SQ   = 3'd4
    } phase_t;
endpackage

// File: rtl/dec_stall_track.sv
// Stall flag tracker: one flag per downstream source, set by a hold pulse
// and cleared by a release pulse. Reports whether any flag is set after
// this cycle's pulses, and flags a release aimed at a clear flag.
// Assumes pulses are single-cycle and synchronous to clk.
module dec_stall_track #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hold_i,
    input  logic [NSRC-1:0] rel_i,
    output logic            any_o,
    output logic            err_o
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] flag_d;

    // next flags: a release in the same cycle as a hold clears
    assign flag_d = (flag_q | hold_i) & ~rel_i;
    assign any_o  = |flag_d;
    assign err_o  = |(rel_i & ~(flag_q | hold_i));

    // flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/dec_pick.sv
// Token picker: scans up to N source entries in order and gathers up to M
// live ones, skipping dead ones for free. Stops consuming once M tokens are
// gathered. Reports the number gathered and the number of entries consumed.
// Purely combinational; unused output slots are zero.
module dec_pick
    import dec_pkg::*;
#(
    parameter int N  = 4,
    parameter int M  = 2,
    parameter int AW = $clog2(N + 1),
    parameter int OW = $clog2(M + 1)
) (
    input  tok_t          src_i [N],
    input  logic [AW-1:0] avail_i,
    output tok_t          out_o [M],
    output logic [OW-1:0] n_o,
    output logic [AW-1:0] used_o
);
    // in-order gather of live tokens
    always_comb begin
        int sent;
        int used;
        sent = 0;
        used = 0;
        for (int k = 0; k < M; k++) out_o[k] = '0;
        for (int j = 0; j < N; j++) begin
            if (j < int'(avail_i) && sent < M) begin
                used = j + 1;
                if (!src_i[j].dead) begin
                    out_o[sent] = src_i[j];
                    sent = sent + 1;
                end
            end
        end
        n_o    = OW'(sent);
        used_o = AW'(used);
    end
endmodule

// File: rtl/dec_skid.sv
// Skid buffer: compacting FIFO where entry 0 is always the oldest.
// Each cycle it removes pop_i entries from the front and appends push_i
// lanes of in_i starting at lane push_off_i. Entries beyond DEPTH are
// dropped (newest first) and ovf_o pulses. Flush empties it.
// Assumes pop_i never exceeds the current count.
module dec_skid
    import dec_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int LANES = 4,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int LW    = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [LW-1:0] pop_i,
    input  logic [LW-1:0] push_i,
    input  logic [LW-1:0] push_off_i,
    input  tok_t          in_i   [LANES],
    output tok_t          head_o [LANES],
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);
    tok_t          mem_q [DEPTH];
    tok_t          mem_d [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // next count and overflow detection
    always_comb begin
        int total;
        total = int'(cnt_q) - int'(pop_i) + int'(push_i);
        ovf_o = !flush_i && (total > DEPTH);
        if (flush_i)            cnt_d = '0;
        else if (total > DEPTH) cnt_d = CW'(DEPTH);
        else                    cnt_d = CW'(total);
    end

    // next contents: shift out popped entries, then append pushed lanes
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            int k;
            int lane;
            src  = i + int'(pop_i);
            k    = src - int'(cnt_q);
            lane = int'(push_off_i) + k;
            mem_d[i] = '0;
            if (src < int'(cnt_q) && src < DEPTH)
                mem_d[i] = mem_q[src];
            else if (k >= 0 && k < int'(push_i) && lane < LANES)
                mem_d[i] = in_i[lane];
        end
    end

    // head view: first LANES entries, zero past the depth
    for (genvar j = 0; j < LANES; j++) begin : g_head
        if (j < DEPTH) begin : g_in
            assign head_o[j] = mem_q[j];
        end else begin : g_out
            assign head_o[j] = '0;
        end
    end

    assign cnt_o = cnt_q;

    // storage and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/decode_stage.sv
// Single-thread decode stage controller. Forwards up to DEC_W live tokens
// per cycle from the fetch bundle (or, while unblocking, from the skid
// buffer). Parks tokens while a downstream stage holds it, pulses fetch to
// stop or go, and flushes on a commit squash. Outputs are combinational in
// the current inputs; phase and buffer update at the edge.
// Assumes fe_cnt <= FETCH_W and that lanes 0..fe_cnt-1 are the valid ones.
module decode_stage
    import dec_pkg::*;
#(
    parameter int FETCH_W   = 4,
    parameter int DEC_W     = 2,
    parameter int F2D_DELAY = 2,
    localparam int SKID_DEPTH = F2D_DELAY * FETCH_W + DEC_W,
    localparam int CNT_W      = $clog2(FETCH_W + 1),
    localparam int OCNT_W     = $clog2(DEC_W + 1),
    localparam int SKC_W      = $clog2(SKID_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         fe_cnt,
    input  logic [FETCH_W*SEQ_W-1:0] fe_seq,
    input  logic [FETCH_W-1:0]       fe_dead,
    input  logic [FETCH_W*SRC_W-1:0] fe_nsrc,
    input  logic                     ren_hold,
    input  logic                     ren_release,
    input  logic                     exe_hold,
    input  logic                     exe_release,
    input  logic                     cmt_hold,
    input  logic                     cmt_release,
    input  logic                     cmt_flush,
    input  logic                     rob_busy,
    output logic [OCNT_W-1:0]        dn_cnt,
    output logic [DEC_W*SEQ_W-1:0]   dn_seq,
    output logic [DEC_W-1:0]         dn_ready,
    output logic                     fe_stop,
    output logic                     fe_go,
    output logic [CNT_W-1:0]         flush_cnt,
    output logic [2:0]               phase,
    output logic                     hold_err,
    output logic                     skid_ovf
);
    phase_t            ph_q, ph_d, ph_eff;
    tok_t              fe_tok   [FETCH_W];
    tok_t              skid_hd  [FETCH_W];
    tok_t              pick_src [FETCH_W];
    tok_t              pick_out [DEC_W];
    logic [OCNT_W-1:0] pick_n;
    logic [CNT_W-1:0]  pick_used, pick_avail;
    logic [SKC_W-1:0]  skid_cnt;
    logic [CNT_W-1:0]  sk_pop, sk_push, sk_off;
    logic              sk_flush, sk_ovf, use_skid, emit, stall_any, stall_err;
    logic              err_q, ovf_q, normal;

    // unpack fetch lanes into tokens
    for (genvar i = 0; i < FETCH_W; i++) begin : g_lane
        assign fe_tok[i].seq  = fe_seq[i*SEQ_W +: SEQ_W];
        assign fe_tok[i].nsrc = fe_nsrc[i*SRC_W +: SRC_W];
        assign fe_tok[i].dead = fe_dead[i];
    end

    dec_stall_track #(.NSRC(N_STALL)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i ({ren_hold, exe_hold, cmt_hold}),
        .rel_i  ({ren_release, exe_release, cmt_release}),
        .any_o  (stall_any),
        .err_o  (stall_err)
    );

    // phase the decode path acts in once no flush, squash or stall applies
    always_comb begin
        case (ph_q)
            PH_BLK:  ph_eff = (skid_cnt == '0) ? PH_RUN : PH_UNB;
            PH_SQ:   ph_eff = PH_RUN;
            default: ph_eff = ph_q;
        endcase
    end

    assign normal   = !cmt_flush && !rob_busy && !stall_any;
    assign use_skid = normal && (ph_eff == PH_UNB);

    // picker source: skid head while unblocking, else the fetch bundle
    always_comb begin
        for (int i = 0; i < FETCH_W; i++)
            pick_src[i] = use_skid ? skid_hd[i] : fe_tok[i];
        if (!use_skid)                             pick_avail = fe_cnt;
        else if (skid_cnt > SKC_W'(FETCH_W))       pick_avail = CNT_W'(FETCH_W);
        else                                       pick_avail = CNT_W'(skid_cnt);
    end

    dec_pick #(.N(FETCH_W), .M(DEC_W)) u_pick (
        .src_i   (pick_src),
        .avail_i (pick_avail),
        .out_o   (pick_out),
        .n_o     (pick_n),
        .used_o  (pick_used)
    );

    dec_skid #(.DEPTH(SKID_DEPTH), .LANES(FETCH_W)) u_skid (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (sk_flush),
        .pop_i      (sk_pop),
        .push_i     (sk_push),
        .push_off_i (sk_off),
        .in_i       (fe_tok),
        .head_o     (skid_hd),
        .cnt_o      (skid_cnt),
        .ovf_o      (sk_ovf)
    );

    // prioritized phase control: flush, rob squash, stall, then decode
    always_comb begin
        ph_d      = ph_q;
        fe_stop   = 1'b0;
        fe_go     = 1'b0;
        sk_flush  = 1'b0;
        sk_pop    = '0;
        sk_push   = '0;
        sk_off    = '0;
        emit      = 1'b0;
        flush_cnt = '0;
        if (cmt_flush) begin
            fe_go     = (ph_q == PH_BLK) || (ph_q == PH_UNB);
            ph_d      = PH_SQ;
            sk_flush  = 1'b1;
            flush_cnt = fe_cnt;
        end else if (rob_busy) begin
            ph_d = PH_SQ;
        end else if (stall_any) begin
            sk_push = fe_cnt;
            fe_stop = (ph_q != PH_BLK);
            ph_d    = PH_BLK;
        end else if (ph_eff == PH_UNB) begin
            emit    = 1'b1;
            sk_pop  = pick_used;
            sk_push = fe_cnt;
            if (int'(skid_cnt) - int'(pick_used) + int'(fe_cnt) == 0) begin
                fe_go = 1'b1;
                ph_d  = PH_RUN;
            end else begin
                ph_d  = PH_UNB;
            end
        end else begin
            emit = 1'b1;
            if (pick_used < fe_cnt) begin
                sk_push = fe_cnt - pick_used;
                sk_off  = pick_used;
                fe_stop = (ph_q != PH_BLK);
                ph_d    = PH_BLK;
            end else begin
                fe_go = (ph_q == PH_BLK);
                ph_d  = ph_eff;
            end
        end
    end

    // downstream slot outputs, gated to the decode path
    always_comb begin
        dn_cnt = emit ? pick_n : '0;
        for (int i = 0; i < DEC_W; i++) begin
            dn_seq[i*SEQ_W +: SEQ_W] = emit ? pick_out[i].seq : '0;
            dn_ready[i] = emit && (i < int'(pick_n)) && (pick_out[i].nsrc == '0);
        end
    end

    // phase register and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            err_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            err_q <= err_q | stall_err;
            ovf_q <= ovf_q | sk_ovf;
        end
    end

    assign phase    = ph_q;
    assign hold_err = err_q;
    assign skid_ovf = ovf_q;
endmodule

// File: rtl/dec_checker.sv
// Protocol checker for decode_stage, attached by bind. Observes ports only.
module dec_checker #(
    parameter int DEC_W = 2,
    parameter int OW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmt_flush,
    input logic          rob_busy,
    input logic          ren_hold,
    input logic          exe_hold,
    input logic          cmt_hold,
    input logic          fe_stop,
    input logic          fe_go,
    input logic [OW-1:0] dn_cnt,
    input logic [2:0]    phase,
    input logic          hold_err,
    input logic          skid_ovf
);
    a_r2_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dn_cnt) <= DEC_W);
    a_r6_flush_to_squashing: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_flush |=> phase == 3'd4);
    a_r6_no_output_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_flush |-> dn_cnt == '0);
    a_r7_rob_holds_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_flush && rob_busy) |=> phase == 3'd4);
    a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_flush && !rob_busy && (ren_hold || exe_hold || cmt_hold)) |=> phase == 3'd2);
    a_r4_stop_not_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        fe_stop |-> phase != 3'd2);
    a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fe_stop && fe_go));
    a_r5_go_leads_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_go && !cmt_flush) |=> phase == 3'd1);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hold_err |=> hold_err);
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        skid_ovf |=> skid_ovf);
endmodule

bind decode_stage dec_checker #(.DEC_W(DEC_W), .OW(OCNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmt_flush (cmt_flush),
    .rob_busy  (rob_busy),
    .ren_hold  (ren_hold),
    .exe_hold  (exe_hold),
    .cmt_hold  (cmt_hold),
    .fe_stop   (fe_stop),
    .fe_go     (fe_go),
    .dn_cnt    (dn_cnt),
    .phase     (phase),
    .hold_err  (hold_err),
    .skid_ovf  (skid_ovf)
);

// File: tb/sim_decode_stage.sv
`timescale 1ns/100ps
module sim_decode_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fe_cnt;
    logic [31:0] fe_seq;
    logic [3:0]  fe_dead;
    logic [11:0] fe_nsrc;
    logic        ren_hold, ren_release, exe_hold, exe_release;
    logic        cmt_hold, cmt_release, cmt_flush, rob_busy;
    logic [1:0]  dn_cnt;
    logic [15:0] dn_seq;
    logic [1:0]  dn_ready;
    logic        fe_stop, fe_go;
    logic [2:0]  flush_cnt;
    logic [2:0]  phase;
    logic        hold_err, skid_ovf;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    decode_stage u0 (
        .clk(clk), .rst_n(rst_n), .fe_cnt(fe_cnt), .fe_seq(fe_seq),
        .fe_dead(fe_dead), .fe_nsrc(fe_nsrc),
        .ren_hold(ren_hold), .ren_release(ren_release),
        .exe_hold(exe_hold), .exe_release(exe_release),
        .cmt_hold(cmt_hold), .cmt_release(cmt_release),
        .cmt_flush(cmt_flush), .rob_busy(rob_busy),
        .dn_cnt(dn_cnt), .dn_seq(dn_seq), .dn_ready(dn_ready),
        .fe_stop(fe_stop), .fe_go(fe_go), .flush_cnt(flush_cnt),
        .phase(phase), .hold_err(hold_err), .skid_ovf(skid_ovf)
    );

    // stall bits {ren, exe, cmt}; zs = lanes with zero sources (others 2)
    typedef struct packed {
        logic [2:0] cnt;  logic [7:0] base; logic [3:0] dead; logic [3:0] zs;
        logic [2:0] hold; logic [2:0] rel;  logic csq; logic rob;
        logic [1:0] e_n;  logic [7:0] e_s0; logic [7:0] e_s1; logic [1:0] e_rdy;
        logic e_stop; logic e_go; logic [2:0] e_fc; logic [2:0] e_ph; logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd0, 4'd11}, // R11 idle empty
        '{3'd2, 8'd10,  4'h0, 4'h1, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd10,  8'd11,  2'b01, 1'b0, 1'b0, 3'd0, 3'd0, 4'd2},  // R2 ready flag
        '{3'd4, 8'd20,  4'h2, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd20,  8'd22,  2'b00, 1'b1, 1'b0, 3'd0, 3'd0, 4'd3},  // R3 dead skip, leftover
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b100, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd2, 4'd4},  // R4 no re-stop
        '{3'd3, 8'd30,  4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd2, 4'd4},  // R4 park
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b100, 1'b0, 1'b0, 2'd2, 8'd23,  8'd30,  2'b00, 1'b0, 1'b0, 3'd0, 3'd2, 4'd5},  // R5 drain
        '{3'd2, 8'd40,  4'h0, 4'h3, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd31,  8'd32,  2'b00, 1'b0, 1'b0, 3'd0, 3'd3, 4'd5},  // R5 append
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd40,  8'd41,  2'b11, 1'b0, 1'b1, 3'd0, 3'd3, 4'd5},  // R5 go
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd11}, // R11 running
        '{3'd1, 8'd50,  4'h0, 4'h1, 3'b000, 3'b000, 1'b0, 1'b1, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd7},  // R7 enter
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b1, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd4, 4'd7},  // R7 hold
        '{3'd2, 8'd60,  4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd60,  8'd61,  2'b00, 1'b0, 1'b0, 3'd0, 3'd4, 4'd6},  // R6 sq->run
        '{3'd2, 8'd70,  4'h0, 4'h0, 3'b010, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b1, 1'b0, 3'd0, 3'd1, 4'd4},  // R4 stop
        '{3'd3, 8'd80,  4'h0, 4'h0, 3'b000, 3'b000, 1'b1, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b1, 3'd3, 3'd2, 4'd6},  // R6 flush
        '{3'd1, 8'd90,  4'h0, 4'h0, 3'b000, 3'b010, 1'b0, 1'b0, 2'd1, 8'd90,  8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd4, 4'd6},  // R6 resume
        '{3'd4, 8'd100, 4'hF, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd2},  // R2 all dead
        '{3'd4, 8'd110, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd110, 8'd111, 2'b00, 1'b1, 1'b0, 3'd0, 3'd1, 4'd3},  // R3
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 8'd112, 8'd113, 2'b00, 1'b0, 1'b1, 3'd0, 3'd2, 4'd6},  // R6 skid was flushed
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd11},
        '{3'd2, 8'd120, 4'h0, 4'h0, 3'b001, 3'b000, 1'b1, 1'b1, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd2, 3'd1, 4'd8},  // R8 flush wins
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b001, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd4, 4'd6},
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd11},
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b100, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b1, 1'b0, 3'd0, 3'd1, 4'd4},
        '{3'd2, 8'd130, 4'h0, 4'h0, 3'b000, 3'b100, 1'b0, 1'b0, 2'd2, 8'd130, 8'd131, 2'b00, 1'b0, 1'b1, 3'd0, 3'd2, 4'd5},  // R5 empty skid
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd11},
        '{3'd1, 8'd140, 4'h0, 4'h0, 3'b010, 3'b000, 1'b0, 1'b1, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd8},  // R8 rob over stall
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b1, 1'b0, 3'd0, 3'd4, 4'd4},
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b010, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b1, 3'd0, 3'd2, 4'd5},
        '{3'd0, 8'd0,   4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 8'd0,   8'd0,   2'b00, 1'b0, 1'b0, 3'd0, 3'd1, 4'd11}
    };

    task automatic drive(input logic [2:0] cnt, input logic [7:0] base,
                         input logic [3:0] dead, input logic [3:0] zs,
                         input logic [2:0] hold, input logic [2:0] rel,
                         input logic csq, input logic rob);
        @(negedge clk);
        fe_cnt  = cnt;
        fe_dead = dead;
        for (int i = 0; i < 4; i++) begin
            fe_seq[i*8 +: 8]  = base + 8'(i);
            fe_nsrc[i*3 +: 3] = zs[i] ? 3'd0 : 3'd2;
        end
        {ren_hold, exe_hold, cmt_hold}          = hold;
        {ren_release, exe_release, cmt_release} = rel;
        cmt_flush = csq;
        rob_busy  = rob;
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: all requirements actual=hung expected=done");
        finish_up();
    end

    initial begin
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset", {phase, hold_err, skid_ovf, fe_stop, fe_go, dn_cnt}, '0);

        foreach (VEC[v]) begin
            vec_t x;
            x = VEC[v];
            drive(x.cnt, x.base, x.dead, x.zs, x.hold, x.rel, x.csq, x.rob);
            check($sformatf("R%0d vector %0d", x.req, v),
                  {dn_cnt, dn_seq[7:0], dn_seq[15:8], dn_ready, fe_stop, fe_go, flush_cnt, phase},
                  {x.e_n, x.e_s0, x.e_s1, x.e_rdy, x.e_stop, x.e_go, x.e_fc, x.e_ph});
        end

        // R9: release aimed at a clear flag sets a sticky error
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b100, 1'b0, 1'b0);
        check("R9 before edge", hold_err, 1'b0);
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R9 set", hold_err, 1'b1);
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R9 sticky", hold_err, 1'b1);

        // R10: three held bundles exceed 10 entries; newest two dropped
        drive(3'd4, 8'd200, 4'h0, 4'h0, 3'b100, 3'b000, 1'b0, 1'b0);
        drive(3'd4, 8'd210, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R10 no overflow at 8", skid_ovf, 1'b0);
        drive(3'd4, 8'd220, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b100, 1'b0, 1'b0);
        check("R10 overflow flag", skid_ovf, 1'b1);
        check("R5 oldest first", {dn_cnt, dn_seq, phase}, {2'd2, 8'd201, 8'd200, 3'd2});
        for (int c = 0; c < 3; c++)
            drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R10 before last pair", {dn_seq, fe_go}, {8'd213, 8'd212, 1'b0});
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R10 last kept pair", {dn_cnt, dn_seq, fe_go}, {2'd2, 8'd221, 8'd220, 1'b1});
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R10 dropped tokens absent", {dn_cnt, phase, skid_ovf}, {2'd0, 3'd1, 1'b1});

        // R1: reset clears sticky flags and phase
        rst_n = 1'b0;
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        rst_n = 1'b1;
        drive(3'd0, 8'd0, 4'h0, 4'h0, 3'b000, 3'b000, 1'b0, 1'b0);
        check("R1 reset clears", {phase, hold_err, skid_ovf}, '0);
        finish_up();
    end
endmodule